// File: doc/BRIEF.md
# Segmented Address Translator with Privilege Check

This block turns a segmented logical address into a 32-bit linear address. It also decides in the same step whether the access is allowed. It keeps a small table of segment descriptors and six segment selector registers. Software-side logic fills both through simple write ports. Each access names one of the six selector registers, gives a 32-bit offset and gives an access kind. The selector in that register picks a descriptor. The block adds the descriptor base to the offset. At the same time it checks the offset against the descriptor limit, checks the current privilege against the descriptor level, and checks the access kind against the segment type.

The current privilege comes from the two low bits of the code selector register. The result appears one clock after the request. It is either a linear address with a zero fault code, or a nonzero fault code with the address forced to zero. A processor front end uses it in front of the paging stage.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_fault` and `rsp_lin` are 0, all six selector registers hold 0 (current privilege 0), and all descriptor entries hold 0.
- R2: A request sampled with `req_valid` high at one rising edge produces `rsp_valid` high after that edge, for exactly that cycle. When no request was sampled, `rsp_valid`, `rsp_fault` and `rsp_lin` are 0.
- R3: With no fault, `rsp_lin` equals descriptor base plus offset, modulo 2^32.
- R4: A selector whose index (bits 15:3) is 0 gives fault code 1 (null). Selector register codes 6 and 7 read as a null selector.
- R5: A selector index of NUM_DESC or above gives fault code 2 (outside table).
- R6: At privilege 0 the descriptor level must be 0 or 3. At privilege 3 the level must be 3. Every other pairing, including privilege or level 1 or 2, gives fault code 3.
- R7: Type nibble bit 3 set means code, clear means data. Bit 1 means readable for code and writable for data. Bits 2 and 0 are ignored. Access kind 0 and 3 are reads, 1 is a write and 2 is an execute. A write to code, an execute from data, a write to a data segment without bit 1, or a read of a code segment without bit 1 gives fault code 4.
- R8: An offset strictly above the zero-extended 20-bit byte limit gives fault code 5. An offset equal to the limit passes.
- R9: When several faults apply, the reported code follows the order null, outside table, privilege, type, limit.
- R10: Selector register writes take effect from the next cycle. Codes 0 to 5 are code, data, stack and three general registers. Only the code register's bits 1:0 set the privilege. The low three bits of other selectors have no effect.
- R11: On any fault, `rsp_lin` is 0.
- R12: A descriptor write stores bits 31:0 as base, 51:32 as limit, 55:52 as type and 57:56 as level. Bits 63:58 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr_en | input | 1 | Selector register write strobe |
| sel_wr_idx | input | 3 | Selector register code (0 code, 1 data, 2 stack, 3-5 general) |
| sel_wr_data | input | 16 | Selector value to store |
| dt_wr_en | input | 1 | Descriptor write strobe |
| dt_wr_idx | input | $clog2(NUM_DESC) | Descriptor entry to write |
| dt_wr_data | input | 64 | Packed descriptor (see R12) |
| req_valid | input | 1 | Access request strobe |
| req_seg | input | 3 | Selector register used by the access |
| req_offset | input | 32 | Offset within the segment |
| req_kind | input | 2 | Access kind (0 read, 1 write, 2 execute, 3 read) |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_fault | output | 3 | Fault code (0 none, 1 null, 2 outside table, 3 privilege, 4 type, 5 limit) |
| rsp_lin | output | 32 | Linear address, zero on fault |

## Verification
The bench sweeps every privilege, level, type nibble and access kind against one descriptor. It puts the offset at the limit, one past it, and well inside. A design with an off-by-one limit compare would fault at the limit or pass one byte past it. A swapped privilege rule would let user code reach kernel descriptors. Further cases are a base that wraps past 2^32, null and out-of-table selectors combined with other faults, which show a wrong priority order, and junk in the selector low bits and the high descriptor bits, which must change nothing.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [2:0] {
    F_NONE  = 3'd0,
    F_NULL  = 3'd1,
    F_RANGE = 3'd2,
    F_PRIV  = 3'd3,
    F_TYPE  = 3'd4,
    F_LIMIT = 3'd5
  } fault_e;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam int SEL_IDX_W = 13;
  localparam int DESC_W    = 58;

  typedef struct packed {
    logic [1:0]  lvl;
    logic [3:0]  kind;
    logic [19:0] limit;
    logic [31:0] base;
  } seg_desc_t;

  // Packed word layout: base 31:0, limit 51:32, type 55:52, level 57:56.
  function automatic seg_desc_t unpack_desc(input logic [DESC_W-1:0] w);
    seg_desc_t d;
    d.base  = w[31:0];
    d.limit = w[51:32];
    d.kind  = w[55:52];
    d.lvl   = w[57:56];
    return d;
  endfunction

  function automatic logic [31:0] lin_sum(input logic [31:0] base,
                                          input logic [31:0] off);
    return base + off;
  endfunction

  function automatic logic priv_ok(input logic [1:0] cpl, input logic [1:0] lvl);
    logic ok;
    unique case (cpl)
      2'd0:    ok = (lvl == 2'd0) || (lvl == 2'd3);
      2'd3:    ok = (lvl == 2'd3);
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  function automatic logic type_ok(input logic is_code, input logic rw_flag,
                                   input logic [1:0] acc);
    logic ok;
    unique case (acc)
      ACC_WRITE: ok = !is_code && rw_flag;
      ACC_EXEC:  ok = is_code;
      default:   ok = !is_code || rw_flag;
    endcase
    return ok;
  endfunction

  function automatic logic limit_ok(input logic [31:0] off, input logic [19:0] limit);
    return off <= {12'h000, limit};
  endfunction

endpackage

// File: rtl/seg_sel_regs.sv
module seg_sel_regs #(
  parameter int NSEG = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_idx,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_idx,
  output logic [15:0] rd_sel,
  output logic [1:0]  cpl
);

  logic [15:0] sel_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        sel_q[g] <= '0;
      else if (wr_en && (wr_idx == 3'(g)))
        sel_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NSEG; i++)
      if (rd_idx == 3'(i)) rd_sel = sel_q[i];
  end

  assign cpl = sel_q[0][1:0];

  // R10: privilege only moves on a write to the code register
  a_r10_cpl_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_idx == 3'd0) |=> $stable(cpl));

  a_r10_cpl_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd0) |=> cpl == $past(wr_data[1:0]));

endmodule

// File: rtl/seg_desc_table.sv
module seg_desc_table import seg_pkg::*; #(
  parameter int NUM_DESC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(NUM_DESC)-1:0] wr_idx,
  input  logic [63:0]                 wr_data,
  input  logic [SEL_IDX_W-1:0]        rd_idx,
  output seg_desc_t                   rd_desc,
  output logic                        rd_in_range
);

  localparam int IW = $clog2(NUM_DESC);

  seg_desc_t ent_q [NUM_DESC];
  logic      unused_hi;

  assign unused_hi = ^wr_data[63:DESC_W];

  for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q[g] <= '0;
      else if (wr_en && (wr_idx == IW'(g)))
        ent_q[g] <= unpack_desc(wr_data[DESC_W-1:0]);
    end
  end

  assign rd_in_range = ({{(32-SEL_IDX_W){1'b0}}, rd_idx} < 32'(NUM_DESC));

  always_comb begin
    rd_desc = '0;
    for (int i = 0; i < NUM_DESC; i++)
      if (rd_idx == SEL_IDX_W'(i)) rd_desc = ent_q[i];
  end

  // R5: an index past the table never reports in range
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx >= SEL_IDX_W'(NUM_DESC)) |-> !rd_in_range);

endmodule

// File: rtl/seg_check.sv
module seg_check import seg_pkg::*; (
  input  logic [SEL_IDX_W-1:0] sel_idx,
  input  logic                 in_range,
  input  seg_desc_t            desc,
  input  logic [31:0]          offset,
  input  logic [1:0]           acc,
  input  logic [1:0]           cpl,
  output logic                 ev_null,
  output logic                 ev_range,
  output logic                 ev_priv,
  output logic                 ev_type,
  output logic                 ev_limit,
  output fault_e               fault,
  output logic [31:0]          lin
);

  logic unused_kind;
  assign unused_kind = desc.kind[2] ^ desc.kind[0];

  assign ev_null  = (sel_idx == '0);
  assign ev_range = !in_range;
  assign ev_priv  = !priv_ok(cpl, desc.lvl);
  assign ev_type  = !type_ok(desc.kind[3], desc.kind[1], acc);
  assign ev_limit = !limit_ok(offset, desc.limit);

  always_comb begin
    if (ev_null)       fault = F_NULL;
    else if (ev_range) fault = F_RANGE;
    else if (ev_priv)  fault = F_PRIV;
    else if (ev_type)  fault = F_TYPE;
    else if (ev_limit) fault = F_LIMIT;
    else               fault = F_NONE;
  end

  assign lin = (fault == F_NONE) ? lin_sum(desc.base, offset) : 32'h0;

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit import seg_pkg::*; #(
  parameter int NUM_DESC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sel_wr_en,
  input  logic [2:0]                  sel_wr_idx,
  input  logic [15:0]                 sel_wr_data,
  input  logic                        dt_wr_en,
  input  logic [$clog2(NUM_DESC)-1:0] dt_wr_idx,
  input  logic [63:0]                 dt_wr_data,
  input  logic                        req_valid,
  input  logic [2:0]                  req_seg,
  input  logic [31:0]                 req_offset,
  input  logic [1:0]                  req_kind,
  output logic                        rsp_valid,
  output logic [2:0]                  rsp_fault,
  output logic [31:0]                 rsp_lin
);

  logic [15:0]          cur_sel;
  logic [1:0]           cpl;
  logic [SEL_IDX_W-1:0] sel_idx;
  seg_desc_t            desc;
  logic                 in_range;
  logic                 ev_null, ev_range, ev_priv, ev_type, ev_limit;
  fault_e               chk_fault;
  logic [31:0]          chk_lin;
  logic                 unused_rpl;

  seg_sel_regs #(.NSEG(6)) u_sel (
    .clk(clk), .rst_n(rst_n),
    .wr_en(sel_wr_en), .wr_idx(sel_wr_idx), .wr_data(sel_wr_data),
    .rd_idx(req_seg), .rd_sel(cur_sel), .cpl(cpl)
  );

  assign sel_idx    = cur_sel[15:3];
  assign unused_rpl = ^cur_sel[2:0];

  seg_desc_table #(.NUM_DESC(NUM_DESC)) u_tab (
    .clk(clk), .rst_n(rst_n),
    .wr_en(dt_wr_en), .wr_idx(dt_wr_idx), .wr_data(dt_wr_data),
    .rd_idx(sel_idx), .rd_desc(desc), .rd_in_range(in_range)
  );

  seg_check u_chk (
    .sel_idx(sel_idx), .in_range(in_range), .desc(desc),
    .offset(req_offset), .acc(req_kind), .cpl(cpl),
    .ev_null(ev_null), .ev_range(ev_range), .ev_priv(ev_priv),
    .ev_type(ev_type), .ev_limit(ev_limit),
    .fault(chk_fault), .lin(chk_lin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 3'd0;
      rsp_lin   <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid ? 3'(chk_fault) : 3'd0;
      rsp_lin   <= req_valid ? chk_lin : 32'h0;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_fault == 3'd0 && rsp_lin == 32'h0));

  a_r3_sum: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_fault != 3'd0 || rsp_lin == $past(desc.base) + $past(req_offset)));

  a_r11_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> rsp_lin == 32'h0);

  a_r4_null: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cur_sel[15:3] == 13'h0) |=> rsp_fault == 3'd1);

  a_r6_user_kernel: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !ev_null && in_range && cpl == 2'd3 && desc.lvl == 2'd0)
    |=> rsp_fault == 3'd3);

  a_r8_limit_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && ev_limit && !ev_null && !ev_range && !ev_priv && !ev_type)
    |=> rsp_fault == 3'd5);

endmodule

// File: tb/sim_seg_xlate_unit.sv
module sim_seg_xlate_unit;

  localparam int ND = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_wr_en = 1'b0;
  logic [2:0]  sel_wr_idx = '0;
  logic [15:0] sel_wr_data = '0;
  logic        dt_wr_en = 1'b0;
  logic [2:0]  dt_wr_idx = '0;
  logic [63:0] dt_wr_data = '0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_seg = '0;
  logic [31:0] req_offset = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic [2:0]  rsp_fault;
  logic [31:0] rsp_lin;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench shadow of what was written
  logic [31:0] m_base  [ND];
  logic [19:0] m_limit [ND];
  logic [3:0]  m_type  [ND];
  logic [1:0]  m_lvl   [ND];
  logic [15:0] m_sel   [6];

  always #2 clk = ~clk;

  seg_xlate_unit #(.NUM_DESC(ND)) u0 (
    .clk(clk), .rst_n(rst_n),
    .sel_wr_en(sel_wr_en), .sel_wr_idx(sel_wr_idx), .sel_wr_data(sel_wr_data),
    .dt_wr_en(dt_wr_en), .dt_wr_idx(dt_wr_idx), .dt_wr_data(dt_wr_data),
    .req_valid(req_valid), .req_seg(req_seg), .req_offset(req_offset),
    .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_lin(rsp_lin)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put_sel(input int r, input logic [15:0] v);
    @(negedge clk);
    sel_wr_en = 1'b1; sel_wr_idx = 3'(r); sel_wr_data = v;
    @(negedge clk);
    sel_wr_en = 1'b0;
    m_sel[r] = v;
  endtask

  task automatic put_desc(input int e, input logic [31:0] b, input logic [19:0] l,
                          input logic [3:0] t, input logic [1:0] d);
    @(negedge clk);
    dt_wr_en = 1'b1; dt_wr_idx = 3'(e);
    dt_wr_data = {6'b101101, d, t, l, b};
    @(negedge clk);
    dt_wr_en = 1'b0;
    m_base[e] = b; m_limit[e] = l; m_type[e] = t; m_lvl[e] = d;
  endtask

  function automatic int model_fault(input int r, input logic [31:0] off, input logic [1:0] k);
    int idx, cpl, lv;
    logic code, flag, bad;
    if (r > 5) return 1;
    idx = int'(m_sel[r] >> 3);
    if (idx == 0) return 1;
    if (idx >= ND) return 2;
    cpl = int'(m_sel[0] & 16'h3);
    lv  = int'(m_lvl[idx]);
    if (!((cpl == 0 && (lv == 0 || lv == 3)) || (cpl == 3 && lv == 3))) return 3;
    code = m_type[idx][3];
    flag = m_type[idx][1];
    if (k == 2'd1)      bad = code | ~flag;
    else if (k == 2'd2) bad = ~code;
    else                bad = code & ~flag;
    if (bad) return 4;
    if ({1'b0, off} > {13'h0, m_limit[idx]}) return 5;
    return 0;
  endfunction

  task automatic access(input string tag, input int r, input logic [31:0] off,
                        input logic [1:0] k);
    int f;
    logic [31:0] el;
    f  = model_fault(r, off, k);
    el = (f != 0) ? 32'h0 : m_base[int'(m_sel[r] >> 3)] + off;
    @(negedge clk);
    req_valid = 1'b1; req_seg = 3'(r); req_offset = off; req_kind = k;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R2 valid"}, {31'h0, rsp_valid}, 32'h1);
    chk({tag, " fault"}, {29'h0, rsp_fault}, 32'(f));
    chk({tag, (f != 0) ? " R11 lin" : " R3 lin"}, rsp_lin, el);
  endtask

  initial begin
    for (int i = 0; i < ND; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_type[i] = '0; m_lvl[i] = '0;
    end
    for (int i = 0; i < 6; i++) m_sel[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 valid", {31'h0, rsp_valid}, 32'h0);
    chk("R1 fault", {29'h0, rsp_fault}, 32'h0);
    chk("R1 lin", rsp_lin, 32'h0);
    // R1/R4: all selectors reset to null
    access("R1 null after reset", 1, 32'h10, 2'd0);

    // R6 R7 R8 R10 R12: full sweep of privilege, level, type, kind
    put_sel(1, 16'h000B);  // index 1, low bits 011 ignored (R10)
    for (int c = 0; c < 4; c++) begin
      put_sel(0, 16'(16'h0038 | c));  // index 7, privilege c
      for (int d = 0; d < 4; d++)
        for (int t = 0; t < 16; t++) begin
          logic [19:0] lim;
          lim = 20'h00400 + 20'(t * 3 + d);
          put_desc(1, 32'h1000_0000 + 32'(c * 4096 + t * 16), lim, 4'(t), 2'(d));
          for (int k = 0; k < 4; k++) begin
            logic [31:0] off;
            case (k % 3)
              0: off = {12'h0, lim};
              1: off = {12'h0, lim} + 1;
              default: off = 32'(k * 7 + t);
            endcase
            access("R6 R7 R8 R12 sweep", 1, off, 2'(k));
          end
        end
    end

    // R8: largest limit boundaries
    put_sel(0, 16'h0000);
    put_desc(2, 32'h0000_4000, 20'hFFFFF, 4'b0010, 2'd0);
    put_sel(2, 16'h0010);
    access("R8 max limit", 2, 32'h000F_FFFF, 2'd1);
    access("R8 past max", 2, 32'h0010_0000, 2'd1);
    access("R8 zero off", 2, 32'h0, 2'd0);

    // R3: base wrap
    put_desc(3, 32'hFFFF_FFF0, 20'h00100, 4'b1010, 2'd3);
    put_sel(3, 16'h0018);
    access("R3 wrap exec", 3, 32'h20, 2'd2);
    access("R3 wrap read", 3, 32'h40, 2'd3);

    // R4 R5 R9: null, range and priority
    put_sel(4, 16'h0007);
    access("R4 null sel", 4, 32'hFFFF_FFFF, 2'd1);
    access("R4 code 6", 6, 32'h0, 2'd0);
    access("R4 code 7", 7, 32'h0, 2'd2);
    put_sel(5, 16'h0040);
    access("R5 index 8", 5, 32'h0, 2'd0);
    put_sel(5, 16'hFFFF);
    access("R5 index max", 5, 32'hFFFF_FFFF, 2'd1);
    put_desc(4, 32'h2000, 20'h10, 4'b1000, 2'd0);
    put_sel(0, 16'h0003);
    put_sel(5, 16'h0020);
    access("R9 priv over type and limit", 5, 32'h100, 2'd1);
    put_sel(0, 16'h0000);
    access("R9 type over limit", 5, 32'h100, 2'd1);
    access("R9 limit only", 5, 32'h100, 2'd2);

    // R10: every selector register reaches its own descriptor
    for (int r = 0; r < 6; r++) begin
      put_desc(r + 1, 32'h0100_0000 * (r + 1), 20'h800, 4'b1110, 2'd3);
      put_sel(r, 16'(((r + 1) << 3) | (r == 0 ? 0 : 7)));
      access("R10 each register", r, 32'h123, 2'd0);
    end
    put_sel(0, 16'h000B);  // privilege 3 via code selector
    access("R10 user via code sel", 1, 32'h10, 2'd0);

    // R2: no response without a request
    @(negedge clk);
    chk("R2 idle valid", {31'h0, rsp_valid}, 32'h0);
    chk("R2 idle lin", rsp_lin, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 190000; n++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule